// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether a frame should be kept based on its destination address. The six destination bytes arrive one per cycle, the first one flagged by a start strobe. While they stream in, the block folds them into a reflected CRC-32. Once the sixth byte has been consumed, it reduces the running value to a 6-bit hash index. That index picks one bit of a 64-bit hash table, and the block presents an accept flag together with a one-cycle valid strobe.

Software loads the hash table as four 16-bit words. Two mode bits widen acceptance:
- Promiscuous mode keeps every frame.
- All-multicast mode keeps any group-addressed frame without looking at the table.

Table writes land in a staging copy, which becomes the active copy only when the next frame starts. A lookup therefore never sees a table that is half updated.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is a CRC-32 with reflected polynomial 0xEDB88320, seeded with 0xFFFFFFFF and not inverted at the end. It runs over exactly six address bytes, each shifted in least-significant bit first, one bit per shift.
- R2: The table index is the low six CRC bits in reversed order (CRC bit 0 becomes index bit 5). Index bits [5:3] choose a table byte and bits [2:0] choose the bit within it, so the index is the linear bit number in the 64-bit table.
- R3: A write with `tbl_sel`=k stores `tbl_wdata` as word k. Its low byte is table byte 2k and its high byte is table byte 2k+1, so table bit n is bit n%16 of word n/16.
- R4: `result_valid` is high for exactly the one cycle after the sixth address byte is consumed, and `accept` is meaningful in that cycle. `result_valid` stays low at every other time.
- R5: With the promiscuous mode bit set, every completed address is accepted.
- R6: An address whose first byte has bit 0 clear is not multicast and is rejected unless promiscuous mode is set.
- R7: With the all-multicast mode bit set, every multicast address is accepted whatever the table holds.
- R8: Table writes take effect from the next frame start. A write issued while a frame is in progress, or in its start cycle, does not change that frame's result.
- R9: Reset clears the whole table and both mode bits, so a multicast address is rejected after reset until the table or a mode is written.
- R10: A start strobe in the middle of an address abandons the partial address. Counting and CRC restart from the new byte, and only the new address produces a result.
- R11: The mode bits are written together through `mode_we` and hold their value between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | `addr_byte` carries an address byte this cycle |
| addr_start | input | 1 | With `addr_valid`, marks the first destination byte |
| addr_byte | input | 8 | Destination address byte |
| tbl_we | input | 1 | Hash table word write strobe |
| tbl_sel | input | 2 | Hash table word number |
| tbl_wdata | input | 16 | Hash table word data |
| mode_we | input | 1 | Mode bit write strobe |
| mode_promisc | input | 1 | Promiscuous mode value to write |
| mode_allmc | input | 1 | All-multicast mode value to write |
| result_valid | output | 1 | One-cycle strobe: decision ready |
| accept | output | 1 | Keep the frame (valid with `result_valid`) |

## Verification
The assertions assume several things about the inputs:
- Address bytes that arrive without a preceding start strobe are to be ignored.
- The mode bits in effect for a decision are the ones held on the cycle the sixth byte is consumed.
- The active table changes only at a frame start.

The stimulus respects these assumptions in the following ways:
- Every frame opens with a start strobe.
- Table and mode writes are issued between frames, except in the directed cases that deliberately write mid-frame or abandon an address part way through.
- The expected decision is computed from a model table that is copied only when the bench drives a start byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W      = 32;
  localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned TBL_BITS   = 1 << IDX_W;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned N_WORDS    = TBL_BITS / WORD_W;
  localparam int unsigned SEL_W      = $clog2(N_WORDS);
  localparam int unsigned CNT_W      = $clog2(ADDR_BYTES + 1);

  // Advance a reflected CRC by one byte, least-significant bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(logic [CRC_W-1:0] c,
                                                     logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [7:0]       din,
  output logic [IDX_W-1:0] hash_idx
);
  logic [CRC_W-1:0] crc_q, crc_d, crc_base;

  always_comb begin
    crc_base = restart ? CRC_SEED : crc_q;
    crc_d    = crc_step_byte(crc_base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= CRC_SEED;
    else if (en) crc_q <= crc_d;
  end

  // Reverse the low CRC bits into the table index.
  for (genvar i = 0; i < IDX_W; i++) begin : g_rev
    assign hash_idx[i] = crc_d[IDX_W-1-i];
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load,
  input  logic [IDX_W-1:0]  idx,
  output logic              hit
);
  logic [TBL_BITS-1:0] staged_q, active_q;
  logic [TBL_BITS-1:0] staged_d, active_d;

  always_comb begin
    staged_d = staged_q;
    active_d = load ? staged_q : active_q;
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        staged_q[k*WORD_W +: WORD_W] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(k)))
        staged_q[k*WORD_W +: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= '0;
    else if (load) active_q <= active_d;
  end

  assign hit = active_q[idx];

  // R8: the table a lookup sees only moves on a frame start.
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
  // R3: a word write leaves every other word of the staging copy untouched.
  p_word_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |=> $stable(staged_q[TBL_BITS-1:WORD_W]));

  logic unused_ok;
  assign unused_ok = ^staged_d;
endmodule

// File: rtl/mhf_seq.sv
module mhf_seq
  import mhf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic first,
  input  logic first_bit0,
  output logic last,
  output logic mc
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mc_q, mc_d;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    mc_d  = mc_q;
    last  = 1'b0;
    if (first) begin
      mc_d  = first_bit0;
      cnt_d = CNT_W'(1);
      last  = (ADDR_BYTES == 1);
    end else if (fire && busy) begin
      cnt_d = cnt_q + CNT_W'(1);
      last  = (cnt_q == CNT_W'(ADDR_BYTES - 1));
    end
    if (last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mc_q  <= mc_d;
    end
  end

  // Multicast flag used on the final byte is the one captured at the start.
  assign mc = first ? first_bit0 : mc_q;

  // R10: the counter never passes the address length.
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_valid,
  input  logic        addr_start,
  input  logic [7:0]  addr_byte,
  input  logic        tbl_we,
  input  logic [1:0]  tbl_sel,
  input  logic [15:0] tbl_wdata,
  input  logic        mode_we,
  input  logic        mode_promisc,
  input  logic        mode_allmc,
  output logic        result_valid,
  output logic        accept
);
  logic             first, last, mc, hit;
  logic [IDX_W-1:0] idx;
  logic             promisc_q, allmc_q;
  logic             valid_q, acc_q, acc_d;

  assign first = addr_valid & addr_start;

  mhf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fire(addr_valid), .first(first),
    .first_bit0(addr_byte[0]), .last(last), .mc(mc)
  );

  mhf_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .en(addr_valid), .restart(first),
    .din(addr_byte), .hash_idx(idx)
  );

  mhf_hash_table u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_sel(SEL_W'(tbl_sel)),
    .wr_data(WORD_W'(tbl_wdata)), .load(first), .idx(idx), .hit(hit)
  );

  always_comb acc_d = promisc_q | (mc & (allmc_q | hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_q <= 1'b0;
      allmc_q   <= 1'b0;
    end else if (mode_we) begin
      promisc_q <= mode_promisc;
      allmc_q   <= mode_allmc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) acc_q <= acc_d;
    end
  end

  assign result_valid = valid_q;
  assign accept       = acc_q;

  // R4: a decision strobe never lasts two cycles.
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R5: promiscuous mode held at the decision forces acceptance.
  p_promisc_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && promisc_q) |=> accept);
  // R6: a non-multicast address without promiscuous mode is rejected.
  p_unicast_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !promisc_q && !mc) |=> !accept);
  // R7: all-multicast mode accepts any group address.
  p_allmc_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && allmc_q && mc) |=> accept);
endmodule

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_valid, addr_start;
  logic [7:0]  addr_byte;
  logic        tbl_we;
  logic [1:0]  tbl_sel;
  logic [15:0] tbl_wdata;
  logic        mode_we, mode_promisc, mode_allmc;
  logic        result_valid, accept;

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] m_staged, m_active;
  logic        m_promisc, m_allmc;

  always #5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
    .addr_byte(addr_byte), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_wdata(tbl_wdata), .mode_we(mode_we), .mode_promisc(mode_promisc),
    .mode_allmc(mode_allmc), .result_valid(result_valid), .accept(accept)
  );

  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    logic [5:0]  ix;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    for (int i = 0; i < 6; i++) ix[i] = c[5-i];
    return ix;
  endfunction

  function automatic logic ref_accept(logic [47:0] a, logic [63:0] t,
                                      logic pr, logic am);
    logic mc;
    mc = a[0];
    return pr | (mc & (am | t[ref_idx(a)]));
  endfunction

  task automatic check(logic got, logic exp, string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr_word(logic [1:0] k, logic [15:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = k; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    m_staged[16*k +: 16] = d;
  endtask

  task automatic wr_table(logic [63:0] t);
    for (int k = 0; k < 4; k++) wr_word(2'(k), t[16*k +: 16]);
  endtask

  task automatic wr_mode(logic pr, logic am);
    @(negedge clk);
    mode_we = 1'b1; mode_promisc = pr; mode_allmc = am;
    @(negedge clk);
    mode_we = 1'b0;
    m_promisc = pr; m_allmc = am;
  endtask

  // Send six bytes; optionally write a table word while byte 2 is driven.
  task automatic send(logic [47:0] a, string req, bit midw,
                      logic [1:0] k, logic [15:0] d);
    logic exp;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 5) check(result_valid, 1'b0, "R4");
      addr_valid = 1'b1;
      addr_start = (i == 0);
      addr_byte  = a[8*i +: 8];
      if (i == 0) m_active = m_staged;
      if (midw && i == 2) begin
        tbl_we = 1'b1; tbl_sel = k; tbl_wdata = d;
        m_staged[16*k +: 16] = d;
      end else begin
        tbl_we = 1'b0;
      end
    end
    exp = ref_accept(a, m_active, m_promisc, m_allmc);
    @(negedge clk);
    addr_valid = 1'b0; addr_start = 1'b0; tbl_we = 1'b0;
    check(result_valid, 1'b1, "R4");
    check(accept, exp, req);
    @(negedge clk);
    check(result_valid, 1'b0, "R4");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [47:0] a;
    logic [5:0]  ix;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    addr_valid = 1'b0; addr_start = 1'b0; addr_byte = '0;
    tbl_we = 1'b0; tbl_sel = '0; tbl_wdata = '0;
    mode_we = 1'b0; mode_promisc = 1'b0; mode_allmc = 1'b0;
    m_staged = '0; m_active = '0; m_promisc = 1'b0; m_allmc = 1'b0;
    repeat (3) @(negedge clk);
    check(result_valid, 1'b0, "R9 reset valid");
    check(accept, 1'b0, "R9 reset accept");
    rst_n = 1'b1;

    // R9: cleared table rejects a multicast address.
    send(48'h0000_5E00_0001 | 48'h1, "R9", 1'b0, 2'd0, 16'd0);

    // R1 R2 R3: only the hashed bit set -> accept; all others -> reject.
    a  = 48'h3322_1100_5E01;
    ix = ref_idx(a);
    wr_table(64'd1 << ix);
    send(a, "R1 R2 R3 single bit", 1'b0, 2'd0, 16'd0);
    check(accept, 1'b1, "R2 hashed bit accepted");
    wr_table(~(64'd1 << ix));
    send(a, "R2 R3 other bits", 1'b0, 2'd0, 16'd0);
    check(accept, 1'b0, "R2 complement rejected");

    // R6: unicast with full table rejected.
    wr_table('1);
    send(48'hAABB_CCDD_EE02, "R6 unicast", 1'b0, 2'd0, 16'd0);

    // R7 and R11: all-multicast with empty table.
    wr_table('0);
    wr_mode(1'b0, 1'b1);
    send(48'h1234_5678_9A03, "R7 allmc", 1'b0, 2'd0, 16'd0);
    send(48'h1234_5678_9A04, "R7 allmc unicast", 1'b0, 2'd0, 16'd0);

    // R5: promiscuous accepts unicast.
    wr_mode(1'b1, 1'b0);
    send(48'h1234_5678_9A04, "R5 promisc", 1'b0, 2'd0, 16'd0);
    wr_mode(1'b0, 1'b0);
    send(48'h1234_5678_9A04, "R11 mode cleared", 1'b0, 2'd0, 16'd0);

    // R8: a mid-frame write of the hashed bit does not affect that frame.
    a  = 48'h0102_0304_0507;
    ix = ref_idx(a);
    send(a, "R8 mid-frame write", 1'b1, 2'(ix >> 4), 16'hFFFF);
    check(accept, 1'b0, "R8 old table used");
    send(a, "R8 next frame", 1'b0, 2'd0, 16'd0);
    check(accept, 1'b1, "R8 new table used");

    // R10: abandon a partial address after three bytes.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      addr_valid = 1'b1; addr_start = (i == 0); addr_byte = 8'hC3 + 8'(i);
    end
    @(negedge clk);
    addr_valid = 1'b0;
    check(result_valid, 1'b0, "R10 partial no result");
    wr_table('0);
    a  = 48'hFEDC_BA98_7611;
    wr_table(64'd1 << ref_idx(a));
    send(a, "R10 restart", 1'b0, 2'd0, 16'd0);

    // Random frames with random tables and modes.
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) == 0)
        wr_word(2'($urandom_range(0, 3)), 16'($urandom));
      if ($urandom_range(0, 19) == 0)
        wr_mode($urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0);
      a = {16'($urandom), 32'($urandom)};
      if ($urandom_range(0, 3) != 0) a[0] = 1'b1;
      send(a, "R1 R2 R3 random", 1'b0, 2'd0, 16'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule